// File: doc/BRIEF.md
# Twin-Mode Dual-Clock FIFO

This block buffers 18-bit words between a write clock domain and a read clock domain. The two clocks may be the same net, or they may be unrelated. The read port runs in one of two timing styles, chosen once at master reset:

- **Standard style.** A word leaves storage only when the reader asks for it.
- **Fall-through style.** The oldest word moves into the output register by itself, and a read request only advances to the next word.

The block reports the following status:

- A write-side flag, whose meaning depends on the style.
- A read-side flag, whose meaning depends on the style.
- A half-full flag.
- Almost-full and almost-empty flags. Their thresholds come from an external offset block.

There are three ways to clear or rewind the block:

- **Master reset** clears everything and samples the style select.
- **Partial reset** clears data and pointers but keeps the latched style.
- **Retransmit** rewinds the read side to memory location zero so that stored data can be read again.

Pointers cross between the domains as Gray code. Each flag is computed in the domain of the side that acts on it.

Top module: `twin_mode_fifo`

## Requirements
- R1: The read style is latched from `mode_sel` while `mrst` is high (0 = standard, 1 = fall-through). Raising `prst` does not change the latched style.
- R2: In standard style, written words stay off `dout` until a read. Each `rd_en` cycle while data is stored puts the next word on `dout` at the following rising `rclk` edge, in write order.
- R3: In fall-through style, the oldest stored word appears on `dout` with `rd_flag` high without any read. Each `rd_en` while `rd_flag` is high moves the next word onto `dout`.
- R4: After a reset with no reads, `wr_flag` behaves as follows:
  - In standard style it means full. It rises on exactly the DEPTH-th write.
  - In fall-through style it means ready for input. It falls on exactly the (DEPTH+1)-th write.
- R5: A write while storage is full is dropped. Every previously stored word still reads back unchanged.
- R6: In standard style, a read while empty is ignored: `dout` keeps its value and `rd_flag` (empty) stays high. A later write then reads back correctly.
- R7: `afull` rises when the number of stored words reaches DEPTH minus `afull_ofs`. This is after DEPTH−m writes in standard style and after DEPTH+1−m writes in fall-through style, where m is `afull_ofs`.
- R8: `aempty` is high while the number of words held is at most `aempty_ofs`. The count includes the output register in fall-through style.
- R9: `half_full` is high while the memory holds more than DEPTH/2 words.
- R10: Partial reset discards all data, returns both pointers to zero, and leaves the block in its latched style.
- R11: Retransmit returns the read pointer to location zero on the next `rclk` edge:
  - In standard style, the next read returns the first word written.
  - In fall-through style, that word reappears on `dout` by itself.
- R12: After master reset in standard style, the outputs are: `rd_flag`=1, `wr_flag`=0, `afull`=0, `aempty`=1, `half_full`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, asynchronous clear |
| prst | input | 1 | Partial reset, active high, keeps latched style |
| mode_sel | input | 1 | Style select, sampled on `wclk` while `mrst` is high |
| wr_en | input | 1 | Write request |
| din | input | DW | Write data |
| afull_ofs | input | AW | Almost-full offset m |
| aempty_ofs | input | AW | Almost-empty offset n |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit request, sampled on `rclk` |
| dout | output | DW | Output register |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| afull | output | 1 | Almost full |
| aempty | output | 1 | Almost empty |
| half_full | output | 1 | More than DEPTH/2 words in memory |

## Verification
The assertions assume the following about the inputs:
- `mode_sel` is settled and each reset is held for several clocks in both domains.
- `rt` is raised only while the write pointer has not wrapped past the depth.
- Writes are idle for the synchronizer latency around a retransmit, because the read pointer then jumps by more than one Gray step.

The stimulus drives one clock into both ports. It holds every reset for three cycles. It waits six cycles after any write before checking read-side flags. It uses retransmit only after fewer than DEPTH writes, with the write port quiet.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
   typedef enum logic {
      RD_STD  = 1'b0,
      RD_FWFT = 1'b1
   } rdmode_e;
endpackage

// File: rtl/gray_sync.sv
module gray_sync #(
   parameter int W      = 5,
   parameter int NSTAGE = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (NSTAGE < 2) begin : g_bad_stages
      $error("gray_sync needs at least two stages");
   end

   logic [W-1:0] stg [NSTAGE];

   for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst)
            if (rst) stg[i] <= '0;
            else     stg[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or posedge rst)
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
      end
   end

   assign q = stg[NSTAGE-1];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
   parameter int AW = 4,
   parameter int DW = 18
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk)
      if (we) mem[waddr] <= wdata;

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
   import fifo_pkg::*;
#(
   parameter int AW     = 4,
   parameter int NSTAGE = 2
) (
   input  logic          wclk,
   input  logic          rst,
   input  rdmode_e       mode,
   input  logic          wr_en,
   input  logic [AW-1:0] afull_ofs,
   input  logic [AW:0]   rgray_in,
   output logic [AW:0]   wgray,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic          wr_flag,
   output logic          afull,
   output logic          half_full
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] wbin, wbin_nxt, rgray_s, rbin_s, wcnt;
   logic        full;

   gray_sync #(.W(AW+1), .NSTAGE(NSTAGE)) u_rsync (
      .clk(wclk), .rst(rst), .d(rgray_in), .q(rgray_s)
   );

   assign rbin_s   = g2b(rgray_s);
   assign wcnt     = wbin - rbin_s;
   assign full     = (wcnt == DEPTH_V);
   assign wr_fire  = wr_en && !full;
   assign wbin_nxt = wbin + (AW+1)'(wr_fire);
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge wclk or posedge rst)
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end

   assign wr_flag   = (mode == RD_FWFT) ? !full : full;
   assign afull     = (wcnt >= (DEPTH_V - {1'b0, afull_ofs}));
   assign half_full = (wcnt > HALF_V);

   a_r5_no_overflow : assert property (@(posedge wclk) disable iff (rst)
      (full && wr_en) |=> $stable(wbin));
   a_r9_full_is_half : assert property (@(posedge wclk) disable iff (rst)
      full |-> half_full);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
   import fifo_pkg::*;
#(
   parameter int AW     = 4,
   parameter int DW     = 18,
   parameter int NSTAGE = 2
) (
   input  logic          rclk,
   input  logic          rst,
   input  rdmode_e       mode,
   input  logic          rd_en,
   input  logic          rt,
   input  logic [AW-1:0] aempty_ofs,
   input  logic [AW:0]   wgray_in,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          aempty
);
   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0]   rbin, rbin_nxt, wgray_s, wbin_s, rcnt;
   logic [AW+1:0] held;
   logic          mem_empty, ovalid, pop, fwft;

   gray_sync #(.W(AW+1), .NSTAGE(NSTAGE)) u_wsync (
      .clk(rclk), .rst(rst), .d(wgray_in), .q(wgray_s)
   );

   assign fwft      = (mode == RD_FWFT);
   assign wbin_s    = g2b(wgray_s);
   assign rcnt      = wbin_s - rbin;
   assign mem_empty = (rcnt == '0);
   assign pop       = !mem_empty && (fwft ? (!ovalid || rd_en) : rd_en);
   assign rbin_nxt  = rt ? '0 : rbin + (AW+1)'(pop);
   assign raddr     = rbin[AW-1:0];

   always_ff @(posedge rclk or posedge rst)
      if (rst) begin
         rbin   <= '0;
         rgray  <= '0;
         ovalid <= 1'b0;
         dout   <= '0;
      end else begin
         rbin  <= rbin_nxt;
         rgray <= rbin_nxt ^ (rbin_nxt >> 1);
         if (rt) begin
            ovalid <= 1'b0;
         end else if (pop) begin
            dout   <= rdata;
            ovalid <= fwft;
         end else if (rd_en) begin
            ovalid <= 1'b0;
         end
      end

   assign held    = {1'b0, rcnt} + (AW+2)'(fwft && ovalid);
   assign aempty  = (held <= {2'b00, aempty_ofs});
   assign rd_flag = fwft ? ovalid : mem_empty;

   a_r6_no_underflow : assert property (@(posedge rclk) disable iff (rst)
      (!fwft && mem_empty && rd_en && !rt) |=> ($stable(rbin) && $stable(dout)));
   a_r11_rewind : assert property (@(posedge rclk) disable iff (rst)
      rt |=> (rbin == '0));
   a_r3_hold_word : assert property (@(posedge rclk) disable iff (rst)
      (fwft && ovalid && !rd_en && !rt) |=> ($stable(dout) && ovalid));
endmodule

// File: rtl/twin_mode_fifo.sv
module twin_mode_fifo
   import fifo_pkg::*;
#(
   parameter int DW     = 18,
   parameter int AW     = 4,
   parameter int NSTAGE = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst,
   input  logic          prst,
   input  logic          mode_sel,
   input  logic          wr_en,
   input  logic [DW-1:0] din,
   input  logic [AW-1:0] afull_ofs,
   input  logic [AW-1:0] aempty_ofs,
   input  logic          rd_en,
   input  logic          rt,
   output logic [DW-1:0] dout,
   output logic          wr_flag,
   output logic          rd_flag,
   output logic          afull,
   output logic          aempty,
   output logic          half_full
);
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end
   if (AW < 2) begin : g_bad_aw
      $error("AW must be at least 2");
   end

   rdmode_e       mode_q;
   logic          rst_any, we;
   logic [AW:0]   wgray, rgray;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;

   assign rst_any = mrst | prst;

   always_ff @(posedge wclk)
      if (mrst) mode_q <= rdmode_e'(mode_sel);

   fifo_wr_side #(.AW(AW), .NSTAGE(NSTAGE)) u_wr (
      .wclk(wclk), .rst(rst_any), .mode(mode_q), .wr_en(wr_en),
      .afull_ofs(afull_ofs), .rgray_in(rgray), .wgray(wgray),
      .wr_fire(we), .waddr(waddr), .wr_flag(wr_flag), .afull(afull),
      .half_full(half_full)
   );

   fifo_ram #(.AW(AW), .DW(DW)) u_ram (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata)
   );

   fifo_rd_side #(.AW(AW), .DW(DW), .NSTAGE(NSTAGE)) u_rd (
      .rclk(rclk), .rst(rst_any), .mode(mode_q), .rd_en(rd_en), .rt(rt),
      .aempty_ofs(aempty_ofs), .wgray_in(wgray), .rdata(rdata),
      .raddr(raddr), .rgray(rgray), .dout(dout), .rd_flag(rd_flag),
      .aempty(aempty)
   );

   a_r1_mode_kept : assert property (@(posedge wclk) disable iff (mrst)
      $past(!mrst) |-> $stable(mode_q));
endmodule

// File: tb/sim_twin_mode_fifo.sv
module sim_twin_mode_fifo;
   localparam int DW = 18;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;
   localparam logic [DW-1:0] VEC [0:7] = '{
      18'h00001, 18'h3FFFF, 18'h2AAAA, 18'h15555,
      18'h00F0F, 18'h01234, 18'h00000, 18'h20001};

   logic clk = 1'b0;
   logic mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, rt = 1'b0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] afull_ofs = 4'd3, aempty_ofs = 4'd2;
   logic [DW-1:0] dout;
   logic wr_flag, rd_flag, afull, aempty, half_full;
   int total = 0, fails = 0;
   logic [DW-1:0] hold;

   always #2 clk = ~clk;

   twin_mode_fifo #(.DW(DW), .AW(AW)) u0 (
      .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
      .wr_en(wr_en), .din(din), .afull_ofs(afull_ofs), .aempty_ofs(aempty_ofs),
      .rd_en(rd_en), .rt(rt), .dout(dout), .wr_flag(wr_flag), .rd_flag(rd_flag),
      .afull(afull), .aempty(aempty), .half_full(half_full)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic master_reset(input logic m);
      @(negedge clk); mrst = 1'b1; mode_sel = m;
      repeat (3) @(negedge clk);
      mrst = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge clk); din = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #200000;
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      // R12: reset state in standard style
      master_reset(1'b0);
      check("R12 rd_flag", rd_flag, 1);
      check("R12 wr_flag", wr_flag, 0);
      check("R12 afull", afull, 0);
      check("R12 aempty", aempty, 1);
      check("R12 half_full", half_full, 0);
      check("R12 dout", dout, 0);

      // R2: vector table walked by one loop, standard style
      for (int i = 0; i < 8; i++) push(VEC[i]);
      idle(6);
      check("R2 no data before read", dout, 0);
      for (int i = 0; i < 8; i++) begin
         pop();
         check("R2 order", dout, VEC[i]);
      end

      // R4 R5 R7 R9: fill in standard style
      master_reset(1'b0);
      for (int i = 0; i < DEPTH; i++) begin
         push(DW'(i * 7 + 3));
         if (i == 7)  check("R9 hf at 8 words", half_full, 0);
         if (i == 8)  check("R9 hf at 9 words", half_full, 1);
         if (i == 11) check("R7 afull at 12 writes", afull, 0);
         if (i == 12) check("R7 afull at 13 writes", afull, 1);
         if (i == 14) check("R4 full at 15 writes", wr_flag, 0);
      end
      check("R4 full at DEPTH writes", wr_flag, 1);
      push(18'h3ABCD);
      idle(6);
      for (int k = 1; k <= DEPTH; k++) begin
         pop();
         check("R5 stored word intact", dout, DW'((k - 1) * 7 + 3));
         if (k == 13) check("R8 aempty with 3 left", aempty, 0);
         if (k == 14) check("R8 aempty with 2 left", aempty, 1);
      end
      check("R6 empty after drain", rd_flag, 1);

      // R6: read while empty
      hold = dout;
      pop();
      check("R6 dout held", dout, hold);
      check("R6 still empty", rd_flag, 1);
      push(VEC[7]);
      idle(6);
      pop();
      check("R6 next word", dout, VEC[7]);

      // R3 R4 R7 R9: fall-through style
      master_reset(1'b1);
      check("R1 fwft no output", rd_flag, 0);
      check("R4 fwft ready", wr_flag, 1);
      push(18'h00100);
      idle(6);
      check("R3 first word falls", dout, 18'h00100);
      check("R3 output ready", rd_flag, 1);
      for (int i = 2; i <= DEPTH + 1; i++) begin
         push(DW'(18'h00100 + i - 1));
         if (i == 9)  check("R9 fwft hf total 9", half_full, 0);
         if (i == 10) check("R9 fwft hf total 10", half_full, 1);
         if (i == 13) check("R7 fwft afull total 13", afull, 0);
         if (i == 14) check("R7 fwft afull total 14", afull, 1);
         if (i == DEPTH) check("R4 fwft ready at DEPTH", wr_flag, 1);
      end
      check("R4 fwft not ready at DEPTH+1", wr_flag, 0);
      idle(6);
      pop();
      check("R3 advance", dout, 18'h00101);
      pop();
      check("R3 advance again", dout, 18'h00102);

      // R11: retransmit, standard style
      master_reset(1'b0);
      for (int i = 0; i < 5; i++) push(VEC[i]);
      idle(6);
      for (int i = 0; i < 3; i++) pop();
      check("R11 std third read", dout, VEC[2]);
      @(negedge clk); rt = 1'b1;
      @(negedge clk); rt = 1'b0;
      idle(4);
      pop();
      check("R11 std rewind", dout, VEC[0]);

      // R11: retransmit, fall-through style
      master_reset(1'b1);
      for (int i = 0; i < 4; i++) push(VEC[i]);
      idle(6);
      check("R3 fwft head", dout, VEC[0]);
      pop(); pop();
      check("R3 fwft after two reads", dout, VEC[2]);
      @(negedge clk); rt = 1'b1;
      @(negedge clk); rt = 1'b0;
      idle(4);
      check("R11 fwft rewind word", dout, VEC[0]);
      check("R11 fwft ready", rd_flag, 1);

      // R10 R1: partial reset keeps fall-through style
      @(negedge clk); prst = 1'b1; mode_sel = 1'b0;
      idle(3);
      prst = 1'b0;
      idle(3);
      check("R10 no data after prst", rd_flag, 0);
      check("R1 style kept, input ready", wr_flag, 1);
      check("R10 aempty after prst", aempty, 1);
      check("R10 hf after prst", half_full, 0);
      push(VEC[5]);
      idle(6);
      check("R10 R1 falls through after prst", dout, VEC[5]);
      check("R1 output ready after prst", rd_flag, 1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule